// File: doc/BRIEF.md
# Nibble-to-Dibit Ethernet Media Adapter

This block sits between the 4-bit transmit and receive paths of an Ethernet MAC and an external PHY. A run-time select picks the PHY link. With the select clear, the adapter is a plain pass-through to a 4-bit MII PHY. With the select set, it drives a reduced-pin RMII PHY. In that mode every transmit nibble is sent as two 2-bit transfers. Received 2-bit transfers are rebuilt into nibbles. The PHY's single carrier-sense/data-valid pin is split back into separate carrier and valid indications for the MAC.

All logic runs from one 50 MHz reference clock. The MAC side of the block steps on a clock enable that the adapter produces. A speed input selects 100 Mb/s, where every reference cycle carries a dibit. At 10 Mb/s each dibit lasts a fixed number of reference cycles. In RMII mode the MAC's transmit-error input is ignored and its collision input is held low.

Top module: `mii_rmii_bridge`

## Requirements
- R1: With `rmii_sel` low, the MAC-side receive outputs equal the MII PHY inputs in the same cycle, the MII transmit outputs equal the MAC transmit inputs, and `rmii_txd`/`rmii_tx_en` are 0.
- R2: With `rmii_sel` high, `mac_col`, `mii_txd`, `mii_tx_en` and `mii_tx_er` are 0, and `mac_tx_er` has no effect on any output.
- R3: `nib_ce` pulses for one cycle every 2 reference cycles when `speed_100` is 1, and every 2*SLOW_DIV cycles when it is 0. The first pulse comes one dibit period after the internal reset releases, and the internal reset releases two clock edges after `rst_n` rises. Under reset `nib_ce` is 0.
- R4: On a cycle with `nib_ce` high, `mac_txd` and `mac_tx_en` are captured. During the next dibit period `rmii_txd` carries bits 1:0 of the captured nibble, and during the period after that it carries bits 3:2. `rmii_tx_en` equals the captured enable for both periods.
- R5: At 10 Mb/s every transmit dibit is held on `rmii_txd` for SLOW_DIV consecutive reference cycles.
- R6: While idle, the receiver ignores dibits other than 01, including 00 dibits seen with `rmii_crs_dv` high. The first 01 dibit seen with `rmii_crs_dv` high becomes the low half of the first nibble. Each completed nibble appears on `mac_rxd` as {second dibit, first dibit}, with `mac_rx_dv` high, on the edge that samples the second dibit.
- R7: The receive inputs are sampled only on the last reference cycle of each dibit period. At 10 Mb/s, values present during the other cycles have no effect.
- R8: `mac_crs` follows the sampled `rmii_crs_dv` while idle. Inside a frame it drops when `rmii_crs_dv` is low on the first dibit of a nibble, and `mac_rx_dv` stays high while data continues.
- R9: When `rmii_crs_dv` is low on both dibits of a nibble, that nibble is not delivered. `mac_rx_dv`, `mac_crs`, `mac_rx_er` and `mac_rxd` go to 0 and the receiver returns to idle.
- R10: `mac_rx_er` is high with a delivered nibble when `rmii_rx_er` was sampled high on either of its dibits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmii_sel | input | 1 | 1 selects the RMII path, 0 the MII pass-through |
| speed_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| nib_ce | output | 1 | Nibble-rate clock enable for the MAC side |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_tx_er | input | 1 | Transmit error from the MAC |
| mac_rxd | output | 4 | Receive nibble to the MAC |
| mac_rx_dv | output | 1 | Receive data valid to the MAC |
| mac_crs | output | 1 | Carrier sense to the MAC |
| mac_col | output | 1 | Collision to the MAC |
| mac_rx_er | output | 1 | Receive error to the MAC |
| mii_txd | output | 4 | MII transmit nibble |
| mii_tx_en | output | 1 | MII transmit enable |
| mii_tx_er | output | 1 | MII transmit error |
| mii_rxd | input | 4 | MII receive nibble |
| mii_rx_dv | input | 1 | MII receive data valid |
| mii_crs | input | 1 | MII carrier sense |
| mii_col | input | 1 | MII collision |
| mii_rx_er | input | 1 | MII receive error |
| rmii_txd | output | 2 | RMII transmit dibit |
| rmii_tx_en | output | 1 | RMII transmit enable |
| rmii_rxd | input | 2 | RMII receive dibit |
| rmii_crs_dv | input | 1 | RMII combined carrier-sense/data-valid |
| rmii_rx_er | input | 1 | RMII receive error |

## Verification
The bench uses the default SLOW_DIV of 10 and runs the RMII path at both values of `speed_100`. This covers both the 2-cycle and the 20-cycle nibble periods, and the 10-cycle hold of each dibit. At the slow rate the bench puts random values on the receive pins in every cycle except the sampling one. This shows that only the sampling cycle has any effect. The received frame includes a false carrier, leading 00 dibits, an odd-length preamble that sets the nibble alignment, an error dibit, a toggling tail and the final two-dibit drop. A last phase drives random values through the MII pass-through.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  typedef enum logic [1:0] {
    RX_IDLE    = 2'd0,
    RX_NEED_LO = 2'd1,
    RX_HAVE_LO = 2'd2
  } rx_state_e;

  localparam logic [1:0] PREAMBLE_DIBIT = 2'b01;
endpackage

// File: rtl/mrb_rate_gen.sv
module mrb_rate_gen #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic speed_100,
  output logic dibit_tick,
  output logic dibit_phase,
  output logic nib_ce
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic [CW-1:0] last_cnt;

  assign last_cnt   = speed_100 ? '0 : SLOW_LAST;
  assign dibit_tick = (cnt_q >= last_cnt);

  always_comb begin
    cnt_d   = dibit_tick ? '0 : cnt_q + 1'b1;
    phase_d = dibit_tick ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign dibit_phase = phase_q;
  assign nib_ce      = dibit_tick & phase_q;

  AST_CE_SPACING: assert property (@(posedge clk) disable iff (!rst_ni)
    nib_ce |=> !nib_ce) else $error("nib_ce on back-to-back cycles"); // R3
endmodule

// File: rtl/mrb_tx_ser.sv
module mrb_tx_ser (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       nib_ce,
  input  logic       dibit_phase,
  input  logic [3:0] txd_in,
  input  logic       tx_en_in,
  output logic [1:0] dibit_out,
  output logic       en_out
);
  logic [3:0] nib_q, nib_d;
  logic       en_q, en_d;

  always_comb begin
    nib_d = nib_q;
    en_d  = en_q;
    if (nib_ce) begin
      nib_d = txd_in;
      en_d  = tx_en_in;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      nib_q <= '0;
      en_q  <= 1'b0;
    end else begin
      nib_q <= nib_d;
      en_q  <= en_d;
    end
  end

  assign dibit_out = dibit_phase ? nib_q[3:2] : nib_q[1:0];
  assign en_out    = en_q;

  AST_TX_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !nib_ce |=> $stable(en_out)) else $error("tx enable moved off a nibble edge"); // R4
endmodule

// File: rtl/mrb_rx_deser.sv
module mrb_rx_deser
  import mrb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       dibit_tick,
  input  logic [1:0] rxd,
  input  logic       crs_dv,
  input  logic       rx_er,
  output logic [3:0] nib_out,
  output logic       dv_out,
  output logic       crs_out,
  output logic       er_out
);
  rx_state_e  st_q, st_d;
  logic [1:0] lo_q, lo_d;
  logic       lo_er_q, lo_er_d;
  logic       lo_low_q, lo_low_d;
  logic [3:0] nib_q, nib_d;
  logic       dv_q, dv_d, crs_q, crs_d, er_q, er_d;

  always_comb begin
    st_d     = st_q;
    lo_d     = lo_q;
    lo_er_d  = lo_er_q;
    lo_low_d = lo_low_q;
    nib_d    = nib_q;
    dv_d     = dv_q;
    crs_d    = crs_q;
    er_d     = er_q;
    if (dibit_tick) begin
      case (st_q)
        RX_IDLE: begin
          crs_d = crs_dv;
          if (crs_dv && rxd == PREAMBLE_DIBIT) begin
            lo_d     = rxd;
            lo_er_d  = rx_er;
            lo_low_d = 1'b0;
            st_d     = RX_HAVE_LO;
          end
        end
        RX_NEED_LO: begin
          lo_d     = rxd;
          lo_er_d  = rx_er;
          lo_low_d = ~crs_dv;
          if (!crs_dv) crs_d = 1'b0;
          st_d     = RX_HAVE_LO;
        end
        RX_HAVE_LO: begin
          if (lo_low_q && !crs_dv) begin
            st_d  = RX_IDLE;
            dv_d  = 1'b0;
            crs_d = 1'b0;
            er_d  = 1'b0;
            nib_d = '0;
          end else begin
            nib_d = {rxd, lo_q};
            dv_d  = 1'b1;
            er_d  = lo_er_q | rx_er;
            st_d  = RX_NEED_LO;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= RX_IDLE;
      lo_q     <= '0;
      lo_er_q  <= 1'b0;
      lo_low_q <= 1'b0;
      nib_q    <= '0;
      dv_q     <= 1'b0;
      crs_q    <= 1'b0;
      er_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      lo_q     <= lo_d;
      lo_er_q  <= lo_er_d;
      lo_low_q <= lo_low_d;
      nib_q    <= nib_d;
      dv_q     <= dv_d;
      crs_q    <= crs_d;
      er_q     <= er_d;
    end
  end

  assign nib_out = nib_q;
  assign dv_out  = dv_q;
  assign crs_out = crs_q;
  assign er_out  = er_q;

  AST_RX_SAMPLE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    !dibit_tick |=> ($stable(dv_out) && $stable(nib_out))) else $error("rx moved between ticks"); // R7
  AST_DV_RISE_WITH_CRS: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(dv_out) |-> crs_out) else $error("valid rose without carrier"); // R8
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(dv_out) |-> (!crs_out && nib_out == 4'd0 && !er_out)) else $error("frame end left state"); // R9
endmodule

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge #(
  parameter int SLOW_DIV = 10
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       rmii_sel,
  input  logic       speed_100,
  output logic       nib_ce,
  input  logic [3:0] mac_txd,
  input  logic       mac_tx_en,
  input  logic       mac_tx_er,
  output logic [3:0] mac_rxd,
  output logic       mac_rx_dv,
  output logic       mac_crs,
  output logic       mac_col,
  output logic       mac_rx_er,
  output logic [3:0] mii_txd,
  output logic       mii_tx_en,
  output logic       mii_tx_er,
  input  logic [3:0] mii_rxd,
  input  logic       mii_rx_dv,
  input  logic       mii_crs,
  input  logic       mii_col,
  input  logic       mii_rx_er,
  output logic [1:0] rmii_txd,
  output logic       rmii_tx_en,
  input  logic [1:0] rmii_rxd,
  input  logic       rmii_crs_dv,
  input  logic       rmii_rx_er
);
  logic       rst_s1_q, rst_s2_q;
  logic       dibit_tick, dibit_phase, ce;
  logic [1:0] ser_dibit;
  logic       ser_en;
  logic [3:0] des_nib;
  logic       des_dv, des_crs, des_er;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  mrb_rate_gen #(.SLOW_DIV(SLOW_DIV)) u_rate (
    .clk(clk_ref), .rst_ni(rst_s2_q), .speed_100(speed_100),
    .dibit_tick(dibit_tick), .dibit_phase(dibit_phase), .nib_ce(ce)
  );

  mrb_tx_ser u_tx (
    .clk(clk_ref), .rst_ni(rst_s2_q), .nib_ce(ce), .dibit_phase(dibit_phase),
    .txd_in(mac_txd), .tx_en_in(mac_tx_en), .dibit_out(ser_dibit), .en_out(ser_en)
  );

  mrb_rx_deser u_rx (
    .clk(clk_ref), .rst_ni(rst_s2_q), .dibit_tick(dibit_tick),
    .rxd(rmii_rxd), .crs_dv(rmii_crs_dv), .rx_er(rmii_rx_er),
    .nib_out(des_nib), .dv_out(des_dv), .crs_out(des_crs), .er_out(des_er)
  );

  assign nib_ce = ce;

  always_comb begin
    if (rmii_sel) begin
      mac_rxd    = des_nib;
      mac_rx_dv  = des_dv;
      mac_crs    = des_crs;
      mac_col    = 1'b0;
      mac_rx_er  = des_er;
      mii_txd    = '0;
      mii_tx_en  = 1'b0;
      mii_tx_er  = 1'b0;
      rmii_txd   = ser_dibit;
      rmii_tx_en = ser_en;
    end else begin
      mac_rxd    = mii_rxd;
      mac_rx_dv  = mii_rx_dv;
      mac_crs    = mii_crs;
      mac_col    = mii_col;
      mac_rx_er  = mii_rx_er;
      mii_txd    = mac_txd;
      mii_tx_en  = mac_tx_en;
      mii_tx_er  = mac_tx_er;
      rmii_txd   = '0;
      rmii_tx_en = 1'b0;
    end
  end

  AST_TX_EN_BETWEEN_NIBBLES: assert property (@(posedge clk_ref) disable iff (!rst_s2_q)
    (rmii_sel && $stable(rmii_sel) && !$past(nib_ce)) |-> $stable(rmii_tx_en))
    else $error("rmii tx enable changed inside a nibble"); // R4
endmodule

// File: tb/tb_mii_rmii_bridge.sv
module tb_mii_rmii_bridge;
  localparam int SLOW = 10;

  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic       rmii_sel = 1'b1, speed_100 = 1'b1;
  logic       nib_ce;
  logic [3:0] mac_txd = '0;
  logic       mac_tx_en = 1'b0, mac_tx_er = 1'b0;
  logic [3:0] mac_rxd;
  logic       mac_rx_dv, mac_crs, mac_col, mac_rx_er;
  logic [3:0] mii_txd;
  logic       mii_tx_en, mii_tx_er;
  logic [3:0] mii_rxd = '0;
  logic       mii_rx_dv = 1'b0, mii_crs = 1'b0, mii_col = 1'b0, mii_rx_er = 1'b0;
  logic [1:0] rmii_txd;
  logic       rmii_tx_en;
  logic [1:0] rmii_rxd = '0;
  logic       rmii_crs_dv = 1'b0, rmii_rx_er = 1'b0;

  mii_rmii_bridge #(.SLOW_DIV(SLOW)) dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .rmii_sel(rmii_sel), .speed_100(speed_100),
    .nib_ce(nib_ce), .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
    .mac_rxd(mac_rxd), .mac_rx_dv(mac_rx_dv), .mac_crs(mac_crs), .mac_col(mac_col),
    .mac_rx_er(mac_rx_er), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en), .mii_tx_er(mii_tx_er),
    .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_crs(mii_crs), .mii_col(mii_col),
    .mii_rx_er(mii_rx_er), .rmii_txd(rmii_txd), .rmii_tx_en(rmii_tx_en),
    .rmii_rxd(rmii_rxd), .rmii_crs_dv(rmii_crs_dv), .rmii_rx_er(rmii_rx_er)
  );

  always #5 clk_ref = ~clk_ref;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0, chk_en = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  int k, n, p;
  logic [3:0] m_last;
  logic m_len, m_tick_prev, m_ce_prev;
  int r_st;                       // 0 idle, 1 waiting low dibit, 2 holding low dibit
  logic [1:0] r_lo;
  logic r_lo_er, r_lo_low, r_dv, r_crs, r_er;
  logic [3:0] r_nib;
  logic [4:0] tx_q[$];            // {en, nibble}
  logic [3:0] rx_q[$];            // {crs_dv, er, dibit}
  logic [3:0] rx_cur;
  int last_ce, ce_seen;

  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      k = 0; n = 0; m_last = '0; m_len = 0; m_tick_prev = 0; m_ce_prev = 0;
      r_st = 0; r_lo = '0; r_lo_er = 0; r_lo_low = 0; r_dv = 0; r_crs = 0; r_er = 0; r_nib = '0;
    end else if (k < 2) begin
      k++;
    end else begin
      bit tick, ce;
      tick = ((n % p) == p - 1);
      ce   = tick && (((n / p) % 2) == 1);
      if (ce) begin m_last = mac_txd; m_len = mac_tx_en; end
      if (tick) begin
        if (r_st == 0) begin
          r_crs = rmii_crs_dv;
          if (rmii_crs_dv && rmii_rxd == 2'b01) begin
            r_lo = rmii_rxd; r_lo_er = rmii_rx_er; r_lo_low = 0; r_st = 2;
          end
        end else if (r_st == 1) begin
          r_lo = rmii_rxd; r_lo_er = rmii_rx_er; r_lo_low = !rmii_crs_dv;
          if (!rmii_crs_dv) r_crs = 0;
          r_st = 2;
        end else begin
          if (r_lo_low && !rmii_crs_dv) begin
            r_st = 0; r_dv = 0; r_crs = 0; r_er = 0; r_nib = '0;
          end else begin
            r_nib = {rmii_rxd, r_lo}; r_dv = 1; r_er = r_lo_er | rmii_rx_er; r_st = 1;
          end
        end
      end
      m_tick_prev = tick;
      m_ce_prev = ce;
      n++;
    end
  end

  always @(posedge clk_ref) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // compare every cycle, then drive the next inputs
  always @(negedge clk_ref) begin
    if (chk_en && !done) begin
      int d;
      bit e_ce;
      d = n / p;
      e_ce = ((n % p) == p - 1) && ((d % 2) == 1);
      chk("R3 nib_ce", nib_ce, e_ce);
      if (nib_ce && rst_n) begin
        if (ce_seen) chk("R3 ce spacing", cyc - last_ce, 2 * p);
        last_ce = cyc; ce_seen = 1;
      end
      if (rmii_sel) begin
        chk("R4 R5 rmii_txd", rmii_txd, (d % 2 == 0) ? m_last[1:0] : m_last[3:2]);
        chk("R4 rmii_tx_en", rmii_tx_en, m_len);
        chk("R6 mac_rxd", mac_rxd, r_nib);
        chk("R6 R9 mac_rx_dv", mac_rx_dv, r_dv);
        chk("R8 mac_crs", mac_crs, r_crs);
        chk("R10 mac_rx_er", mac_rx_er, r_er);
        chk("R2 mac_col", mac_col, 0);
        chk("R2 mii tx quiet", {mii_txd, mii_tx_en, mii_tx_er}, 0);
      end else begin
        chk("R1 mac_rx side", {mac_rxd, mac_rx_dv, mac_crs, mac_col, mac_rx_er},
            {mii_rxd, mii_rx_dv, mii_crs, mii_col, mii_rx_er});
        chk("R1 mii tx side", {mii_txd, mii_tx_en, mii_tx_er}, {mac_txd, mac_tx_en, mac_tx_er});
        chk("R1 rmii tx quiet", {rmii_txd, rmii_tx_en}, 0);
      end
    end
    // stimulus
    if (rmii_sel) begin
      mac_tx_er = 1'($urandom);      // R2: must not matter
      if (m_ce_prev) begin
        if (tx_q.size() > 0) begin
          logic [4:0] t;
          t = tx_q.pop_front();
          mac_tx_en = t[4]; mac_txd = t[3:0];
        end else begin
          mac_tx_en = 0; mac_txd = '0;
        end
      end
      if (m_tick_prev) rx_cur = (rx_q.size() > 0) ? rx_q.pop_front() : 4'b0000;
      if (((n % p) == p - 1) && k >= 2) begin
        {rmii_crs_dv, rmii_rx_er, rmii_rxd} = rx_cur;
      end else begin
        {rmii_crs_dv, rmii_rx_er, rmii_rxd} = 4'($urandom);   // R7: off-tick noise
      end
    end else begin
      {mii_rxd, mii_rx_dv, mii_crs, mii_col, mii_rx_er} = 8'($urandom);
      {mac_txd, mac_tx_en, mac_tx_er} = 6'($urandom);
    end
  end

  task automatic push_db(input bit crs, input bit er, input logic [1:0] db);
    rx_q.push_back({crs, er, db});
  endtask

  task automatic push_nib(input bit crs_a, input bit crs_b, input bit er, input logic [3:0] v);
    push_db(crs_a, er, v[1:0]);
    push_db(crs_b, 1'b0, v[3:2]);
  endtask

  task automatic load_frame();
    for (int i = 0; i < 16; i++) tx_q.push_back({1'b1, 4'(i * 7 + 3)});
    push_db(1, 0, 2'b00); push_db(0, 0, 2'b00); push_db(0, 0, 2'b10);   // R8 false carrier
    for (int i = 0; i < 3; i++) push_db(1, 0, 2'b00);                 // R6 leading 00
    for (int i = 0; i < 7; i++) push_db(1, 0, 2'b01);                 // R6 odd preamble
    push_db(1, 0, 2'b11);
    push_nib(1, 1, 0, 4'hA); push_nib(1, 1, 1, 4'h5);                 // R10 error dibit
    push_nib(1, 1, 0, 4'h3); push_nib(0, 1, 0, 4'hC);                 // R8 toggling tail
    push_nib(0, 1, 0, 4'h9);
    push_db(0, 0, 2'b10); push_db(0, 0, 2'b01);                       // R9 full drop
  endtask

  task automatic do_reset(input bit spd);
    rst_n = 0; chk_en = 0; ce_seen = 0;
    speed_100 = spd; p = spd ? 1 : SLOW;
    rx_cur = 4'b0000;
    repeat (3) @(negedge clk_ref);
    chk_en = 1;
    @(posedge clk_ref); #1;
    chk("R3 reset nib_ce", nib_ce, 0);
    chk("R4 reset tx_en", rmii_tx_en, 0);
    chk("R9 reset rx_dv", mac_rx_dv, 0);
    @(negedge clk_ref);
    rst_n = 1;
  endtask

  initial begin
    p = 1;
    rmii_sel = 1;
    do_reset(1'b1);
    load_frame();
    wait (tx_q.size() == 0 && rx_q.size() == 0);
    repeat (40) @(negedge clk_ref);
    do_reset(1'b0);
    load_frame();
    wait (tx_q.size() == 0 && rx_q.size() == 0);
    repeat (400) @(negedge clk_ref);
    rmii_sel = 0;
    repeat (60) @(negedge clk_ref);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule